// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches an SDRAM-style command bus and finds flash operations hidden inside ordinary command encodings. Each clock it decodes the chip-select, row-strobe, column-strobe and write-enable pins together with bank, address and data. It follows multi-cycle sequences in two forms. The hardware form opens with a load-command-register cycle that carries a command code. The software form uses only ACTIVE and WRITE cycles with fixed key values, so a plain SDRAM controller can issue it.

When a sequence completes, the decoder emits a one-cycle operation strobe with the decoded operation, bank, row, column and data. Idle-type cycles may appear between the steps of a sequence. Any other command, or a change of bank, abandons the sequence without issuing anything. A one-time enable bit, cleared by the disable operation, permanently turns the hardware form off.

Top module: `fcmd_seq_decoder`

## Requirements
- R1: Pins {csN,rasN,casN,weN} decode as: 1xxx inhibit, 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 burst stop, 0010 active end, 0001 load-command-register (LCR), 0000 load-mode. Inhibit is recognised from csN alone, whatever the other three pins carry.
- R2: Hardware form: LCR (code on addr[7:0]), then ACTIVE (row on addr), then WRITE (column on addr[7:0], data on data) issues the operation.
- R3: Code to opCode: 90h→0 read config, 70h→1 read status, 50h→2 clear status, 20h→3 erase, 40h→4 program, 60h→5 protect, 30h→6 erase nvmode, A0h→7 program nvmode on banks 0/1 or →8 disable LCR on banks 2/3, 68h→9 chip init. Any other code starts no sequence.
- R4: Short software form: ACTIVE with row 088h, WRITE with the code on addr[7:0] and data[7:0] not 55h, ACTIVE with the target row, then the final WRITE.
- R5: Long software form: ACTIVE row 088h, WRITE data[7:0]=55h, WRITE data[7:0]=A0h, WRITE with the code on addr[7:0], ACTIVE with the target row, then the final WRITE.
- R6: Erase issues only if the final data[7:0] is D0h. Chip init and erase nvmode issue only if it is C0h. Any other value abandons the sequence.
- R7: An ACTIVE or WRITE inside a sequence whose bank differs from the first cycle's bank abandons the sequence.
- R8: Any command not tolerated by R9, or any ACTIVE or WRITE out of its place, abandons the sequence. That cycle starts nothing new.
- R9: Inhibit, NOP, burst stop and active end between steps leave a sequence in progress. In the software form an LCR cycle is also tolerated.
- R10: The LCR enable starts at 1. An issued disable-LCR operation clears it, and it never sets again without reset. While it is 0, LCR acts as NOP, the hardware form issues nothing, and the software forms still work.
- R11: opValid is high for exactly one cycle, in the cycle after the final WRITE is sampled. The opCode, opBank, opRow, opCol and opData outputs hold until the next issued operation.
- R12: After reset opValid is 0, opCode is Fh and the LCR enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address |
| addr | input | ROW_W | Row, column or command code |
| data | input | DATA_W | Write data |
| opValid | output | 1 | One-cycle operation strobe |
| opCode | output | 4 | Decoded operation (R3 encoding) |
| opBank | output | BANK_W | Bank of the operation |
| opRow | output | ROW_W | Row of the operation |
| opCol | output | COL_W | Column of the final WRITE |
| opData | output | DATA_W | Data of the final WRITE |

## Verification
Several properties are checked on every cycle: the single-cycle strobe, outputs that hold between operations, the sticky enable bit and its one legal cause, the erase confirm value, and the return to idle after a READ, a bank change, or a disabled LCR. The full mapping from codes and banks to operations, the three sequence shapes, the tolerance of interleaved idle cycles, and the hardware form going dead after disable while the software forms keep working can only be shown by the bench's directed and random sequences.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT, CMD_NOP, CMD_ACTIVE, CMD_READ, CMD_WRITE,
    CMD_BSTOP, CMD_ACTEND, CMD_LCR, CMD_LMODE
  } cmd_e;

  typedef enum logic [3:0] {
    OP_READ_CFG  = 4'd0, OP_READ_STAT = 4'd1, OP_CLR_STAT = 4'd2,
    OP_ERASE     = 4'd3, OP_PROGRAM   = 4'd4, OP_PROTECT  = 4'd5,
    OP_ERASE_NVM = 4'd6, OP_PROG_NVM  = 4'd7, OP_DIS_LCR  = 4'd8,
    OP_CHIP_INIT = 4'd9, OP_NONE      = 4'd15
  } op_e;

  localparam logic [7:0] KEY_ROW    = 8'h88;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hA0;
  localparam logic [7:0] CONF_ERASE = 8'hD0;
  localparam logic [7:0] CONF_INIT  = 8'hC0;

  // control -> datapath strobes
  typedef struct packed {
    logic latchBank;
    logic latchCode;
    logic latchRow;
    logic fire;
  } strobe_t;

  function automatic cmd_e decodeCmd(input logic [3:0] pins);
    if (pins[3]) return CMD_INHIBIT;
    case (pins[2:0])
      3'b111:  return CMD_NOP;
      3'b011:  return CMD_ACTIVE;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b110:  return CMD_BSTOP;
      3'b010:  return CMD_ACTEND;
      3'b001:  return CMD_LCR;
      default: return CMD_LMODE;
    endcase
  endfunction

  function automatic op_e codeToOp(input logic [7:0] code, input logic upperBank);
    case (code)
      8'h90:   return OP_READ_CFG;
      8'h70:   return OP_READ_STAT;
      8'h50:   return OP_CLR_STAT;
      8'h20:   return OP_ERASE;
      8'h40:   return OP_PROGRAM;
      8'h60:   return OP_PROTECT;
      8'h30:   return OP_ERASE_NVM;
      8'hA0:   return upperBank ? OP_DIS_LCR : OP_PROG_NVM;
      8'h68:   return OP_CHIP_INIT;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic confirmMatch(input op_e op, input logic [7:0] d);
    case (op)
      OP_ERASE:                   return d == CONF_ERASE;
      OP_CHIP_INIT, OP_ERASE_NVM: return d == CONF_INIT;
      default:                    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fcmd_dpath.sv
module fcmd_dpath
  import fcmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output logic              bankMatch,
  output logic              codeKnown,
  output logic              confirmOk,
  output logic              isKeyRow,
  output logic              isKey1,
  output logic              isKey2,
  output logic              lcrEn,
  output logic              opValid,
  output op_e               opCode,
  output logic [BANK_W-1:0] opBank,
  output logic [ROW_W-1:0]  opRow,
  output logic [COL_W-1:0]  opCol,
  output logic [DATA_W-1:0] opData
);

  localparam int SEL_BIT = 1;  // banks 2/3 select the upper A0h variant

  logic [BANK_W-1:0] bankQ;
  logic [7:0]        codeQ;
  logic [ROW_W-1:0]  rowQ;
  logic              lcrEnQ;
  op_e               curOp;

  assign curOp     = codeToOp(codeQ, bankQ[SEL_BIT]);
  assign bankMatch = (bank == bankQ);
  assign codeKnown = (codeToOp(addr[7:0], 1'b0) != OP_NONE);
  assign confirmOk = confirmMatch(curOp, data[7:0]);
  assign isKeyRow  = (addr == ROW_W'(KEY_ROW));
  assign isKey1    = (data[7:0] == KEY_FIRST);
  assign isKey2    = (data[7:0] == KEY_SECOND);
  assign lcrEn     = lcrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ  <= '0;
      codeQ  <= '0;
      rowQ   <= '0;
    end else begin
      if (strb.latchBank) bankQ <= bank;
      if (strb.latchCode) codeQ <= addr[7:0];
      if (strb.latchRow)  rowQ  <= addr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcrEnQ  <= 1'b1;
      opValid <= 1'b0;
      opCode  <= OP_NONE;
      opBank  <= '0;
      opRow   <= '0;
      opCol   <= '0;
      opData  <= '0;
    end else begin
      opValid <= strb.fire;
      if (strb.fire) begin
        opCode <= curOp;
        opBank <= bankQ;
        opRow  <= rowQ;
        opCol  <= addr[COL_W-1:0];
        opData <= data;
        if (curOp == OP_DIS_LCR) lcrEnQ <= 1'b0;
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid); // R11
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> ($stable(opRow) && $stable(opCode) && $stable(opData))); // R11
  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !lcrEnQ |=> !lcrEnQ); // R10
  AST_FUSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcrEnQ) |-> (opValid && opCode == OP_DIS_LCR)); // R10
  AST_ERASE_CONF: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ERASE) |-> (opData[7:0] == CONF_ERASE)); // R6

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cmdPins,
  input  logic       bankMatch,
  input  logic       codeKnown,
  input  logic       confirmOk,
  input  logic       isKeyRow,
  input  logic       isKey1,
  input  logic       isKey2,
  input  logic       lcrEn,
  output strobe_t    strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HW_ACT, ST_HW_WR, ST_SW_KEY, ST_SW_K2, ST_SW_CODE, ST_SW_ACT, ST_SW_WR
  } state_e;

  state_e stateQ, stateD;
  cmd_e   cmd;
  logic   inSw, tolerated;

  assign cmd  = decodeCmd(cmdPins);
  assign inSw = (stateQ inside {ST_SW_KEY, ST_SW_K2, ST_SW_CODE, ST_SW_ACT, ST_SW_WR});
  assign tolerated = (cmd inside {CMD_INHIBIT, CMD_NOP, CMD_BSTOP, CMD_ACTEND}) ||
                     (cmd == CMD_LCR && (inSw || !lcrEn));

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    if (stateQ == ST_IDLE) begin
      if (cmd == CMD_LCR && lcrEn && codeKnown) begin
        strb.latchBank = 1'b1;
        strb.latchCode = 1'b1;
        stateD = ST_HW_ACT;
      end else if (cmd == CMD_ACTIVE && isKeyRow) begin
        strb.latchBank = 1'b1;
        stateD = ST_SW_KEY;
      end
    end else if (!tolerated) begin
      stateD = ST_IDLE;
      if (bankMatch) begin
        case (stateQ)
          ST_HW_ACT, ST_SW_ACT: if (cmd == CMD_ACTIVE) begin
            strb.latchRow = 1'b1;
            stateD = (stateQ == ST_HW_ACT) ? ST_HW_WR : ST_SW_WR;
          end
          ST_HW_WR, ST_SW_WR: if (cmd == CMD_WRITE && confirmOk) strb.fire = 1'b1;
          ST_SW_KEY: if (cmd == CMD_WRITE) begin
            if (isKey1) stateD = ST_SW_K2;
            else if (codeKnown) begin
              strb.latchCode = 1'b1;
              stateD = ST_SW_ACT;
            end
          end
          ST_SW_K2: if (cmd == CMD_WRITE && isKey2) stateD = ST_SW_CODE;
          ST_SW_CODE: if (cmd == CMD_WRITE && codeKnown) begin
            strb.latchCode = 1'b1;
            stateD = ST_SW_ACT;
          end
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_READ_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && cmd == CMD_READ) |=> stateQ == ST_IDLE); // R8
  AST_BANK_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && (cmd == CMD_ACTIVE || cmd == CMD_WRITE) && !bankMatch)
      |=> stateQ == ST_IDLE); // R7
  AST_LCR_DEAD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !lcrEn && cmd == CMD_LCR) |=> stateQ == ST_IDLE); // R10
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && cmd == CMD_NOP) |=> stateQ == $past(stateQ)); // R9

endmodule

// File: rtl/fcmd_seq_decoder.sv
module fcmd_seq_decoder
  import fcmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output logic              opValid,
  output logic [3:0]        opCode,
  output logic [BANK_W-1:0] opBank,
  output logic [ROW_W-1:0]  opRow,
  output logic [COL_W-1:0]  opCol,
  output logic [DATA_W-1:0] opData
);

  strobe_t strb;
  logic    bankMatch, codeKnown, confirmOk, isKeyRow, isKey1, isKey2, lcrEn;
  op_e     opCodeE;

  fcmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdPins({csN, rasN, casN, weN}),
    .bankMatch(bankMatch), .codeKnown(codeKnown), .confirmOk(confirmOk),
    .isKeyRow(isKeyRow), .isKey1(isKey1), .isKey2(isKey2), .lcrEn(lcrEn),
    .strb(strb)
  );

  fcmd_dpath #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bank(bank), .addr(addr), .data(data),
    .bankMatch(bankMatch), .codeKnown(codeKnown), .confirmOk(confirmOk),
    .isKeyRow(isKeyRow), .isKey1(isKey1), .isKey2(isKey2), .lcrEn(lcrEn),
    .opValid(opValid), .opCode(opCodeE), .opBank(opBank), .opRow(opRow),
    .opCol(opCol), .opData(opData)
  );

  assign opCode = opCodeE;

endmodule

// File: tb/fcmd_seq_decoder_tb_top.sv
`timescale 1ns/1ps
module fcmd_seq_decoder_tb_top;

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_BST = 4'b0110, P_AEND = 4'b0010, P_LCR = 4'b0001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, csN, rasN, casN, weN, opValid;
  logic [1:0] bank, opBank;
  logic [11:0] addr, opRow;
  logic [15:0] data, opData;
  logic [3:0] opCode;
  logic [7:0] opCol;

  fcmd_seq_decoder dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bank(bank), .addr(addr), .data(data), .opValid(opValid), .opCode(opCode),
    .opBank(opBank), .opRow(opRow), .opCol(opCol), .opData(opData)
  );

  int nCmp = 0, nBad = 0;
  bit fuseM = 1'b1;
  bit done = 1'b0;
  logic [7:0] codes [9] = '{8'h90, 8'h70, 8'h50, 8'h20, 8'h40, 8'h60, 8'h30, 8'hA0, 8'h68};

  function automatic logic [3:0] expOp(input logic [7:0] c, input logic [1:0] b);
    case (c)
      8'h90: return 4'd0;  8'h70: return 4'd1;  8'h50: return 4'd2;
      8'h20: return 4'd3;  8'h40: return 4'd4;  8'h60: return 4'd5;
      8'h30: return 4'd6;  8'hA0: return b[1] ? 4'd8 : 4'd7;
      8'h68: return 4'd9;  default: return 4'd15;
    endcase
  endfunction

  function automatic logic [8:0] confOf(input logic [7:0] c);
    case (c)
      8'h20:        return {1'b1, 8'hD0};
      8'h68, 8'h30: return {1'b1, 8'hC0};
      default:      return 9'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setPins(input logic [3:0] p, input logic [1:0] b, input logic [11:0] a,
                         input logic [15:0] d);
    {csN, rasN, casN, weN} = p;
    bank = b; addr = a; data = d;
    @(negedge clk);
  endtask

  task automatic pad(input bit allowLcr);
    int n;
    n = $urandom % 3;
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom % (allowLcr ? 5 : 4);
      case (r)
        0: setPins(4'b1000 | 4'($urandom % 8), 2'($urandom), 12'($urandom), 16'($urandom));
        1: setPins(P_NOP, 2'($urandom), 12'($urandom), 16'($urandom));
        2: setPins(P_BST, 2'($urandom), 12'($urandom), 16'($urandom));
        3: setPins(P_AEND, 2'($urandom), 12'($urandom), 16'($urandom));
        default: setPins(P_LCR, 2'($urandom), 12'($urandom), 16'($urandom));
      endcase
    end
  endtask

  // form: 0 hardware, 1 short software, 2 long software
  // fault: 0 none, 1 bank change, 2 READ inserted, 3 wrong confirm
  task automatic runSeq(input int form, input logic [7:0] code, input logic [1:0] bk,
                        input logic [11:0] row, input logic [7:0] col, input logic [15:0] datIn,
                        input int faultIn, input bit usePad, input string req);
    logic [3:0]  cP [6];
    logic [11:0] cA [6];
    logic [15:0] cD [6];
    logic [15:0] dat;
    logic [8:0]  cf;
    logic [1:0]  b;
    logic [42:0] act, exp;
    int n, fault;
    bit expV;
    dat = datIn; fault = faultIn;
    cf = confOf(code);
    if (cf[8]) dat[7:0] = cf[7:0];
    if (fault == 3) begin
      if (cf[8]) dat[7:0] = dat[7:0] ^ 8'h01;
      else fault = 0;
    end
    if (form == 0) begin
      cP[0] = P_LCR; cA[0] = {4'h0, code}; cD[0] = 16'h0;
      cP[1] = P_ACT; cA[1] = row;          cD[1] = 16'h0;
      cP[2] = P_WR;  cA[2] = {4'h0, col};  cD[2] = dat;
      n = 3;
    end else if (form == 1) begin
      cP[0] = P_ACT; cA[0] = 12'h088;      cD[0] = 16'h0;
      cP[1] = P_WR;  cA[1] = {4'h0, code}; cD[1] = 16'h0;
      cP[2] = P_ACT; cA[2] = row;          cD[2] = 16'h0;
      cP[3] = P_WR;  cA[3] = {4'h0, col};  cD[3] = dat;
      n = 4;
    end else begin
      cP[0] = P_ACT; cA[0] = 12'h088;      cD[0] = 16'h0;
      cP[1] = P_WR;  cA[1] = 12'($urandom); cD[1] = 16'h0055;
      cP[2] = P_WR;  cA[2] = 12'($urandom); cD[2] = 16'h00A0;
      cP[3] = P_WR;  cA[3] = {4'h0, code}; cD[3] = 16'h0;
      cP[4] = P_ACT; cA[4] = row;          cD[4] = 16'h0;
      cP[5] = P_WR;  cA[5] = {4'h0, col};  cD[5] = dat;
      n = 6;
    end
    for (int i = 0; i < n; i++) begin
      b = bk;
      if (i > 0 && usePad) pad(form != 0 && fault == 0);
      if (i == 1 && fault == 2) setPins(P_RD, bk, 12'h0, 16'h0);
      if (i == 1 && fault == 1) b = bk ^ 2'b01;
      setPins(cP[i], b, cA[i], cD[i]);
    end
    expV = (fault == 0) && (form != 0 || fuseM);
    act = {opValid, opCode, opBank, opRow, opCol, opData};
    if (expV) begin
      exp = {1'b1, expOp(code, bk), bk, row, col, dat};
      check(req, 64'(act), 64'(exp));
      if (expOp(code, bk) == 4'd8) fuseM = 1'b0;
    end else begin
      check(req, 64'(opValid), 64'd0);
    end
    setPins(P_NOP, 2'b00, 12'h0, 16'h0);
    check("R11 pulse width", 64'(opValid), 64'd0);
  endtask

  task automatic randSeq(input bit allowDis);
    int form, f, fault;
    logic [7:0] code;
    logic [1:0] bk;
    logic [11:0] row;
    string req;
    form = $urandom % 3;
    code = codes[$urandom % 9];
    bk = 2'($urandom);
    if (!allowDis && code == 8'hA0) bk[1] = 1'b0;
    row = 12'($urandom);
    if (row == 12'h088) row = 12'h123;
    f = $urandom % 6;
    fault = (f < 3) ? 0 : f - 2;
    case (fault)
      1: req = "R7 random bank change";
      2: req = "R8 random illegal command";
      3: req = "R6 random wrong confirm";
      default: req = (form == 0) ? "R2 R3 random hardware form" :
                     (form == 1) ? "R4 R3 random short form" : "R5 R3 random long form";
    endcase
    runSeq(form, code, bk, row, 8'($urandom), 16'($urandom), fault, bit'($urandom % 2), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    {csN, rasN, casN, weN} = P_NOP; bank = 0; addr = 0; data = 0;
    repeat (3) @(negedge clk);
    check("R12 reset opValid", 64'(opValid), 64'd0);
    check("R12 reset opCode", 64'(opCode), 64'hF);
    rstN = 1'b1;
    @(negedge clk);

    // directed corner cases
    runSeq(0, 8'h20, 2'd1, 12'h3A5, 8'h17, 16'h12D0, 0, 1'b0, "R2 R6 hardware erase");
    // inhibit carrying load-mode-like pins between steps (R1, R9)
    setPins(P_LCR, 2'd2, 12'h040, 16'h0);
    setPins(4'b1000, 2'd0, 12'h0, 16'h0);
    setPins(P_NOP, 2'd3, 12'h0, 16'h0);
    setPins(P_ACT, 2'd2, 12'h7FF, 16'h0);
    setPins(P_BST, 2'd0, 12'h0, 16'h0);
    setPins(P_AEND, 2'd1, 12'h0, 16'h0);
    setPins(P_WR, 2'd2, 12'h0C3, 16'hBEEF);
    check("R1 R9 program with idle cycles",
          64'({opValid, opCode, opBank, opRow, opCol, opData}),
          64'({1'b1, 4'd4, 2'd2, 12'h7FF, 8'hC3, 16'hBEEF}));
    setPins(P_NOP, 2'd0, 12'h0, 16'h0);
    // unknown code starts nothing
    setPins(P_LCR, 2'd0, 12'h011, 16'h0);
    setPins(P_ACT, 2'd0, 12'h222, 16'h0);
    setPins(P_WR, 2'd0, 12'h033, 16'h0);
    check("R3 unknown code", 64'(opValid), 64'd0);
    check("R11 outputs held", 64'({opCode, opRow, opData}), 64'({4'd4, 12'h7FF, 16'hBEEF}));
    runSeq(0, 8'hA0, 2'd0, 12'h010, 8'h02, 16'h0001, 0, 1'b0, "R3 program nvmode bank0");
    runSeq(1, 8'h40, 2'd3, 12'h400, 8'hFE, 16'h5A5A, 0, 1'b1, "R4 short program");
    runSeq(2, 8'h68, 2'd2, 12'h001, 8'h00, 16'h0000, 0, 1'b1, "R5 long chip init");
    runSeq(2, 8'h30, 2'd1, 12'h002, 8'h05, 16'h0000, 3, 1'b0, "R6 erase nvmode bad confirm");
    runSeq(0, 8'h20, 2'd0, 12'h100, 8'h01, 16'h0000, 3, 1'b0, "R6 erase bad confirm");
    runSeq(1, 8'h50, 2'd2, 12'h0AB, 8'h44, 16'h7777, 1, 1'b0, "R7 bank change");
    runSeq(0, 8'h70, 2'd1, 12'h0CD, 8'h66, 16'h8888, 2, 1'b0, "R8 read aborts");
    // software form tolerates LCR cycles
    setPins(P_ACT, 2'd1, 12'h088, 16'h0);
    setPins(P_LCR, 2'd3, 12'h040, 16'h0);
    setPins(P_WR, 2'd1, 12'h060, 16'h0);
    setPins(P_LCR, 2'd0, 12'h020, 16'h0);
    setPins(P_ACT, 2'd1, 12'h555, 16'h0);
    setPins(P_WR, 2'd1, 12'h099, 16'h1234);
    check("R9 LCR inside software form",
          64'({opValid, opCode, opBank, opRow, opCol, opData}),
          64'({1'b1, 4'd5, 2'd1, 12'h555, 8'h99, 16'h1234}));
    setPins(P_NOP, 2'd0, 12'h0, 16'h0);

    for (int i = 0; i < 120; i++) randSeq(1'b0);

    runSeq(0, 8'hA0, 2'd3, 12'h0FF, 8'h10, 16'hCAFE, 0, 1'b0, "R10 disable LCR");
    runSeq(0, 8'h40, 2'd0, 12'h321, 8'h20, 16'h1111, 0, 1'b0, "R10 hardware form dead");
    runSeq(1, 8'h40, 2'd0, 12'h321, 8'h20, 16'h1111, 0, 1'b0, "R10 software form after disable");
    runSeq(0, 8'hA0, 2'd2, 12'h0FE, 8'h11, 16'h2222, 0, 1'b0, "R10 no second disable by LCR");

    for (int i = 0; i < 120; i++) randSeq(1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule